// File: doc/BRIEF.md
# Null-Terminated String Output Engine

This block carries out the string-print trap of a 16-bit processor. When the decode stage presents the trap word 0xF022, the engine captures the value of general register R0 as a start address and walks memory upward one word at a time. The low byte of each word goes out as a character on a valid/ready byte stream. The walk ends at the first word that reads as zero, which is not sent, or after address 0xFFFF has been handled. The walk never wraps back to address 0.

While the engine works it raises `busy`, and the fetch stage holds on that signal. The `busy` flag rises combinationally in the cycle the trap word is seen, so the processor never fetches past the trap. When the walk finishes, `done` pulses for one cycle. The memory port is a synchronous read: the address and `mem_rd_en` are presented in one cycle, and `mem_rd_data` is valid in the next. A slow consumer can hold `chr_ready` low. The engine then keeps the pending character and does not move on to the next address.

Top module: `strout_engine`

## Requirements
- R1: A walk starts only in a cycle where `instr_valid` is high and `instr` equals 0xF022. Any other word leaves `busy` low and issues no memory read.
- R2: The first memory read of a walk uses the value `r0_value` held in the cycle the trap was accepted.
- R3: Reads go to consecutive ascending addresses, one word per character. Read data is taken one cycle after `mem_rd_en`.
- R4: `chr_data` carries bits 7:0 of the word that was read, and the upper byte is discarded. A word whose low byte is zero but whose upper byte is not is still sent, as character 0x00.
- R5: A walk ends at the first word equal to 0x0000, and that word is not sent.
- R6: After the character at address 0xFFFF is accepted, the walk ends. Address 0x0000 is not read.
- R7: `busy` is high in the cycle the trap is seen and stays high until the walk ends. `chr_valid` is only high while `busy` is high.
- R8: While `chr_valid` is high and `chr_ready` is low, `chr_valid` stays high, `chr_data` stays unchanged and no new read is made. No character is lost or repeated.
- R9: `done` is high for exactly one cycle, in the cycle after the last `busy` cycle of a walk.
- R10: A trap word presented while a walk is in progress is ignored, and the current walk continues unchanged.
- R11: During and right after reset, `busy`, `done`, `chr_valid` and `mem_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | `instr` holds a decoded instruction this cycle |
| instr | input | 16 | Instruction word |
| r0_value | input | 16 | Current contents of general register R0 |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_data | input | 16 | Read data, one cycle after the request |
| chr_valid | output | 1 | A character is offered |
| chr_data | output | 8 | Character byte |
| chr_ready | input | 1 | The consumer takes the character |
| busy | output | 1 | Walk in progress; the fetch stage holds |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench starts a walk at the top of the address space, with a non-zero word sitting at address 0. A design that wraps would keep sending characters and miss the expected count. It starts another walk directly on a terminator, so a design that sends the zero word, or does not finish with no output, gives a wrong count. A word with a zero low byte and a non-zero upper byte sits inside a string: an engine that tests only the emitted byte stops early there. Several ready patterns, including long stalls, and a second trap word sent mid-walk expose lost or duplicated characters and restarted walks. Instruction words that differ from the trap in one field must leave `busy` and the read port idle.

// File: rtl/strout_pkg.sv
// Package: shared widths and the sequencing state type for the string
// output engine. Assumes 16-bit words and 8-bit characters by default.
package strout_pkg;
    localparam int unsigned ADDR_W_DEF = 16;
    localparam int unsigned WORD_W_DEF = 16;
    localparam int unsigned CHAR_W_DEF = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for the trap word
        ST_FETCH = 2'd1,   // read request on the memory port
        ST_EVAL  = 2'd2,   // read data present, test for terminator
        ST_EMIT  = 2'd3    // character offered on the stream
    } strout_state_e;
endpackage

// File: rtl/strout_trap_match.sv
// Module: recognises the string-print trap word. The match is qualified by
// the instruction strobe and by an arm input, so that words seen while a
// walk is running are ignored. Purely combinational.
module strout_trap_match #(
    parameter int unsigned WORD_W    = 16,
    parameter logic [WORD_W-1:0] TRAP_CODE = 16'hF022
) (
    input  logic              armed,
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr,
    output logic              hit
);
    // Full-word compare: every bit must equal the trap code.
    always_comb begin
        hit = armed && instr_valid && (instr == TRAP_CODE);
    end
endmodule

// File: rtl/strout_addr_walk.sv
// Module: address register for the memory walk. It loads the start address
// and then increments by one per step. It flags the last address of the
// space; the caller must not step past it (no wrap is relied upon).
module strout_addr_walk #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    // Address register: load has priority over step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_addr;
        end else if (step) begin
            addr <= addr + 1'b1;
        end
    end

    // End-of-space detect on the current address.
    always_comb begin
        at_last = (addr == LAST_ADDR);
    end
endmodule

// File: rtl/strout_char_reg.sv
// Module: single-entry output holding register for the character stream.
// It captures a byte and offers it until the consumer accepts it. It
// assumes capture is never requested while a byte is still pending.
module strout_char_reg #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [CHAR_W-1:0] byte_in,
    input  logic              ready,
    output logic              valid,
    output logic [CHAR_W-1:0] byte_out,
    output logic              accepted
);
    // Handshake completes when both sides agree in the same cycle.
    always_comb begin
        accepted = valid && ready;
    end

    // Valid flag: set by capture, cleared by acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else if (capture) begin
            valid <= 1'b1;
        end else if (accepted) begin
            valid <= 1'b0;
        end
    end

    // Data register: changes only on capture, so it is stable while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_out <= '0;
        end else if (capture) begin
            byte_out <= byte_in;
        end
    end
endmodule

// File: rtl/strout_engine.sv
// Module: top of the string output engine. On the trap word it walks memory
// from R0, sending each word's low byte until a zero word or the end of the
// address space. It assumes a synchronous memory read with one cycle of
// latency. Busy stalls the fetch stage; done pulses once per walk.
module strout_engine
    import strout_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF,
    parameter int unsigned WORD_W = WORD_W_DEF,
    parameter int unsigned CHAR_W = CHAR_W_DEF,
    parameter logic [WORD_W-1:0] TRAP_CODE = 16'hF022
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr,
    input  logic [ADDR_W-1:0] r0_value,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              chr_valid,
    output logic [CHAR_W-1:0] chr_data,
    input  logic              chr_ready,
    output logic              busy,
    output logic              done
);
    strout_state_e state_q, state_d;
    logic trap_hit;
    logic addr_load, addr_step, at_last;
    logic chr_capture, chr_accepted;
    logic finish;
    logic done_q;
    logic word_is_zero;

    // Trap recogniser, armed only when no walk is running.
    strout_trap_match #(
        .WORD_W    (WORD_W),
        .TRAP_CODE (TRAP_CODE)
    ) u_match (
        .armed       (state_q == ST_IDLE),
        .instr_valid (instr_valid),
        .instr       (instr),
        .hit         (trap_hit)
    );

    // Walking address register.
    strout_addr_walk #(
        .ADDR_W (ADDR_W)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (addr_load),
        .load_addr (r0_value),
        .step      (addr_step),
        .addr      (mem_rd_addr),
        .at_last   (at_last)
    );

    // Output holding register for the character stream.
    strout_char_reg #(
        .CHAR_W (CHAR_W)
    ) u_chr (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (chr_capture),
        .byte_in  (mem_rd_data[CHAR_W-1:0]),
        .ready    (chr_ready),
        .valid    (chr_valid),
        .byte_out (chr_data),
        .accepted (chr_accepted)
    );

    // Terminator test on the whole word, not just the emitted byte.
    always_comb begin
        word_is_zero = (mem_rd_data == '0);
    end

    // Next-state and control decode for the walk sequence.
    always_comb begin
        state_d     = state_q;
        addr_load   = 1'b0;
        addr_step   = 1'b0;
        chr_capture = 1'b0;
        finish      = 1'b0;
        mem_rd_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (trap_hit) begin
                    addr_load = 1'b1;
                    state_d   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_rd_en = 1'b1;
                state_d   = ST_EVAL;
            end
            ST_EVAL: begin
                if (word_is_zero) begin
                    finish  = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    chr_capture = 1'b1;
                    state_d     = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (chr_accepted) begin
                    if (at_last) begin
                        finish  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        addr_step = 1'b1;
                        state_d   = ST_FETCH;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Completion pulse, one cycle after the final walk cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
        end
    end

    // Busy covers the detection cycle and every walk cycle.
    always_comb begin
        busy = trap_hit || (state_q != ST_IDLE);
        done = done_q;
    end
endmodule

// File: rtl/strout_engine_chk.sv
// Module: property checker for the string output engine, bound to the top.
// It observes ports only and assumes the synchronous active-low reset.
module strout_engine_chk #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd_en,
    input logic [WORD_W-1:0] mem_rd_data,
    input logic              chr_valid,
    input logic [CHAR_W-1:0] chr_data,
    input logic              chr_ready,
    input logic              busy,
    input logic              done
);
    AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd_en);                                          // R1
    AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid |-> busy);                                            // R7
    AST_CHAR_FROM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chr_valid) |-> $past(mem_rd_data) != '0);                 // R5
    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && !chr_ready) |=> chr_valid);                       // R8
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && !chr_ready) |=> $stable(chr_data));               // R8
    AST_NO_READ_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid |-> !mem_rd_en);                                      // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                // R9
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));                                   // R9
endmodule

bind strout_engine strout_engine_chk #(
    .WORD_W (WORD_W),
    .CHAR_W (CHAR_W)
) u_chk (.*);

// File: tb/strout_engine_tb.sv
// Bench: walks a vector table of (start address, instruction, ready
// pattern), then directed tests for reset, busy timing, mid-walk traps
// and stalls. Expected strings come from a bench-side memory walk.
module strout_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] r0_value = '0;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic [15:0] mem_rd_data = '0;
    logic        chr_valid;
    logic [7:0]  chr_data;
    logic        chr_ready;
    logic        busy;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;

    strout_engine u_dut (.*);

    always #5 clk = ~clk;

    // Memory model: 256 words, mirrored over the address space.
    logic [15:0] bmem [0:255];
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= bmem[mem_rd_addr[7:0]];

    // Vector: {r0[15:0], instr[15:0], ready mode[3:0]}
    localparam int NVEC = 8;
    localparam logic [35:0] VEC [0:NVEC-1] = '{
        {16'h0000, 16'hF022, 4'd0},
        {16'h0011, 16'hF022, 4'd1},
        {16'h0010, 16'hF022, 4'd0},
        {16'h0030, 16'hF022, 4'd2},
        {16'hFFF8, 16'hF022, 4'd1},
        {16'h0005, 16'hF023, 4'd0},
        {16'h0005, 16'h7022, 4'd0},
        {16'h00F0, 16'hF022, 4'd3}
    };

    // Monitor state
    int        mode = 0;
    logic      stall = 1'b0;
    int        cyc = 0;
    logic [7:0] got [0:511];
    int        ngot = 0;
    int        nread = 0;
    logic [15:0] first_addr = '0;
    int        ndone = 0;
    logic      busy_seen = 1'b0;
    logic      busy_after_done = 1'b0;
    logic      prev_done = 1'b0;
    logic      done_wide = 1'b0;

    // Drive ready, then record what the coming edge will see.
    always @(negedge clk) begin
        cyc++;
        case (mode)
            1: chr_ready = ~stall && (cyc % 2 == 0);
            2: chr_ready = ~stall && (cyc % 3 == 0);
            3: chr_ready = ~stall && (cyc % 8 == 7);
            default: chr_ready = ~stall;
        endcase
        #1;
        if (rst_n) begin
            if (chr_valid && chr_ready && ngot < 512) begin got[ngot] = chr_data; ngot++; end
            if (mem_rd_en) begin if (nread == 0) first_addr = mem_rd_addr; nread++; end
            if (busy) busy_seen = 1'b1;
            if (done) ndone++;
            if (done && prev_done) done_wide = 1'b1;
            if (ndone > 0 && busy && !instr_valid) busy_after_done = 1'b1;
            prev_done = done;
        end
    end

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        ngot = 0; nread = 0; ndone = 0; busy_seen = 0;
        busy_after_done = 0; done_wide = 0; prev_done = 0;
    endtask

    // Expected walk, computed from the requirements.
    task automatic expect_walk(input logic [15:0] start, output logic [7:0] ex [0:511], output int nex);
        logic [16:0] a;
        nex = 0;
        a = {1'b0, start};
        while (a <= 17'h0FFFF) begin
            if (bmem[a[7:0]] == 16'h0000) break;
            ex[nex] = bmem[a[7:0]][7:0];
            nex++;
            a = a + 1;
        end
    endtask

    task automatic issue(input logic [15:0] r0, input logic [15:0] iw);
        @(negedge clk);
        #2;
        r0_value = r0; instr = iw; instr_valid = 1'b1;
        @(negedge clk);
        #2;
        instr_valid = 1'b0; instr = '0; r0_value = 16'hDEAD;
    endtask

    task automatic wait_done(input int limit);
        for (int k = 0; k < limit && ndone == 0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic compare(input logic [15:0] r0, input string tag);
        logic [7:0] ex [0:511];
        int nex;
        expect_walk(r0, ex, nex);
        chk(ngot == nex, {tag, " R5 R6 char count"}, ngot, nex);
        for (int j = 0; j < nex && j < ngot; j++)
            chk(got[j] == ex[j], {tag, " R3 R4 char"}, got[j], ex[j]);
        chk(nread > 0 && first_addr == r0, {tag, " R2 first address"}, first_addr, r0);
        chk(ndone == 1 && !done_wide, {tag, " R9 done pulse"}, ndone, 1);
        chk(!busy && !busy_after_done, {tag, " R7 busy released"}, busy, 0);
    endtask

    // Watchdog
    initial begin
        #1_500_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = {8'h80 | i[7:0], i[7:0] ^ 8'h5A};
        bmem[8'h10] = 16'h0000;
        bmem[8'h28] = 16'h0000;
        bmem[8'h40] = 16'h0000;
        bmem[8'h1C] = 16'h0100;   // R4: low byte zero, not a terminator

        // R11: reset state
        repeat (3) @(negedge clk);
        #2;
        chk(!busy && !done && !chr_valid && !mem_rd_en, "R11 outputs during reset",
            {busy, done, chr_valid, mem_rd_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(!busy && !done && !chr_valid && !mem_rd_en, "R11 outputs after reset",
            {busy, done, chr_valid, mem_rd_en}, 0);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] r0, iw;
            r0 = VEC[v][35:20]; iw = VEC[v][19:4]; mode = int'(VEC[v][3:0]);
            clear_mon();
            issue(r0, iw);
            if (iw == 16'hF022) begin
                wait_done(4000);
                compare(r0, $sformatf("vec%0d", v));
            end else begin
                repeat (20) @(negedge clk);
                chk(!busy_seen && nread == 0 && ngot == 0, "R1 non-trap word ignored",
                    {busy_seen, nread[7:0]}, 0);
            end
        end

        // R7: busy rises in the cycle the trap is presented
        mode = 0; clear_mon();
        @(negedge clk);
        #2;
        r0_value = 16'h0030; instr = 16'hF022; instr_valid = 1'b1;
        #1;
        chk(busy == 1'b1, "R7 busy in detection cycle", busy, 1);
        @(negedge clk);
        #2;
        instr_valid = 1'b0; instr = '0; r0_value = 16'hDEAD;
        wait_done(4000);
        compare(16'h0030, "r7_run");

        // R10: second trap during a walk is ignored
        mode = 1; clear_mon();
        issue(16'h0000, 16'hF022);
        repeat (6) @(negedge clk);
        #2;
        r0_value = 16'h0030; instr = 16'hF022; instr_valid = 1'b1;
        @(negedge clk);
        #2;
        instr_valid = 1'b0; instr = '0;
        wait_done(4000);
        compare(16'h0000, "R10 mid-walk trap");

        // R8: long stall holds the pending character
        mode = 0; clear_mon();
        stall = 1'b1;
        issue(16'h0020, 16'hF022);
        repeat (4) @(negedge clk);
        begin
            logic [7:0] held;
            logic stable_ok;
            #2;
            held = chr_data; stable_ok = chr_valid;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                #2;
                if (!chr_valid || chr_data != held || mem_rd_en) stable_ok = 1'b0;
            end
            chk(stable_ok, "R8 stall holds character", chr_data, held);
            chk(ngot == 0, "R8 nothing taken while stalled", ngot, 0);
        end
        stall = 1'b0;
        wait_done(4000);
        compare(16'h0020, "R8 after stall");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule